// File: doc/BRIEF.md
# Double-Buffered Parallel Pattern Player

The block loops a stored frame of 8-bit patterns onto a parallel output, one pattern per clock, so that each output bit acts as its own waveform channel. Patterns sit four to a 32-bit word in a frame of `FRAME_WORDS` words, 625 by default, which gives 2500 patterns per loop. The lowest byte of each word is played first. The block reads one word ahead of the word it is playing. This keeps the output free of gaps at word boundaries and across the wrap from the last word back to the first.

Two equal banks hold frames. One bank is played. The other is open to a host port that can write it and read it back, which lets a controller edit a whole frame, for example by shifting one channel in phase. A swap request makes the banks change roles. During playback the change happens only at a frame boundary, so the output never mixes two frames. While playback is off, the change happens on the next edge.

The output is a stream with a valid flag and no back-pressure: a downstream stage must take every pattern that appears with `pat_valid` high. The host port is memory-like. A host access to an address of `FRAME_WORDS` or above is not allowed.

Top module: `pattern_player`

## Requirements
- R1: After reset, `pat_out` is 0, `pat_valid` is 0, `swap_done` is 0, bank 0 plays and the host port addresses bank 1.
- R2: The first pattern is byte 0 of word 0 of the playing bank. It appears on `pat_out` with `pat_valid` high right after the second rising edge that follows the edge which first samples `play_en` high. Before that, `pat_valid` stays low.
- R3: The four patterns of a word come out in this order: bits [7:0], [15:8], [23:16], [31:24]. While `play_en` stays high, `pat_valid` stays high on every cycle, with no bubble between words.
- R4: Word `FRAME_WORDS-1` is followed at once by word 0 of the same frame, with no idle cycle.
- R5: `host_we` writes `host_wdata` to `host_addr` of the bank that is not playing. The played stream does not change.
- R6: After the edge that samples `host_re` high, `host_rdata` holds the word at `host_addr` of the bank that is not playing, and it keeps that value until the next read.
- R7: During playback, a swap request takes effect at the next frame boundary only if an edge registers it before the edge on which in-frame pattern `4*FRAME_WORDS-5` appears. From that boundary, pattern 0 of the newly playing bank follows the last pattern of the old frame with no gap. A request registered later waits for the following frame.
- R8: `swap_done` is high for exactly one cycle per role exchange. During playback that cycle is the one in which in-frame pattern `4*FRAME_WORDS-5` of the last old frame is on `pat_out`. Host accesses sampled from the next edge on go to the other bank.
- R9: While playback is off, a pending swap request exchanges the banks on the next edge, and `swap_done` rises on the second edge after the request was sampled.
- R10: When `play_en` is sampled low, `pat_out` becomes 0 and `pat_valid` becomes 0 at that edge. When playback is enabled again, it restarts at word 0 of the playing bank.
- R11: Any number of swap requests registered before one role exchange produce a single exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pattern per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Playback enable; low forces an idle all-zero output |
| swap_req | input | 1 | Request to exchange the roles of the banks |
| host_we | input | 1 | Write strobe into the bank that is not playing |
| host_re | input | 1 | Read strobe from the bank that is not playing |
| host_addr | input | $clog2(FRAME_WORDS) | Word address for host access |
| host_wdata | input | 32 | Word to write, four patterns packed with the lowest byte first |
| host_rdata | output | 32 | Read-back word, one cycle after `host_re` |
| pat_out | output | 8 | Current output pattern, one bit per channel |
| pat_valid | output | 1 | High while `pat_out` carries a played pattern |
| swap_done | output | 1 | One-cycle pulse when the banks exchange roles |

## Verification
The bench shrinks the frame to four words and checks every played pattern against a value it computes from the bank version, the word index and the byte index. It therefore catches a byte order that is reversed, a bubble at a word edge or at the frame wrap, and a swap that lands mid-frame or one frame late. It requests a swap twice within one frame. A design that toggled the banks on each request would switch back, or would pulse `swap_done` twice. Host writes run during playback and bank contents are read back after two role exchanges. A host port that reached the playing bank would therefore corrupt the stream or the read-back data. Disable, re-enable and idle swap check the restart from word 0 and the two-edge delay of an idle swap.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_PRIME = 2'd1,
    PS_RUN   = 2'd2
  } play_state_e;

endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DEPTH  = 625,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              pa_en,
  input  logic [ADDR_W-1:0] pa_addr,
  output logic [WIDTH-1:0]  pa_data,
  input  logic              pb_en,
  input  logic [ADDR_W-1:0] pb_addr,
  output logic [WIDTH-1:0]  pb_data
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Playback read port: read before write on a shared address.
  always_ff @(posedge clk) begin
    if (pa_en) pa_data <= store[pa_addr];
  end

  // Host read-back port.
  always_ff @(posedge clk) begin
    if (pb_en) pb_data <= store[pb_addr];
  end

endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int FRAME_WORDS = 625,
  parameter int LANE_W      = 8,
  parameter int SLOTS       = 4,
  localparam int WORD_W     = LANE_W * SLOTS,
  localparam int ADDR_W     = $clog2(FRAME_WORDS),
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_en,
  input  logic [WORD_W-1:0] fetch_data,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              wrap_fetch,
  output logic              idle,
  output logic [LANE_W-1:0] pat_out,
  output logic              pat_valid
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(FRAME_WORDS - 1);

  play_state_e       state;
  logic [WORD_W-1:0] cur_word;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] word_idx;
  logic [LANE_W-1:0] lane_sel;
  logic [ADDR_W-1:0] addr_next;

  assign idle      = (state == PS_IDLE);
  assign addr_next = (fetch_addr == LAST_WORD) ? '0 : fetch_addr + 1'b1;

  // A read is issued when playback starts, while the first word is
  // primed, and on the last slot of every word; that keeps one word
  // waiting in the bank output register.
  always_comb begin
    fetch_en = 1'b0;
    if (play_en) begin
      unique case (state)
        PS_IDLE:  fetch_en = 1'b1;
        PS_PRIME: fetch_en = 1'b1;
        PS_RUN:   fetch_en = (slot == LAST_SLOT);
        default:  fetch_en = 1'b0;
      endcase
    end
  end

  assign wrap_fetch = fetch_en && (state == PS_RUN) && (fetch_addr == '0);

  always_comb begin
    lane_sel = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (slot == SLOT_W'(k)) lane_sel = cur_word[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PS_IDLE;
      cur_word   <= '0;
      slot       <= '0;
      word_idx   <= '0;
      fetch_addr <= '0;
      pat_out    <= '0;
      pat_valid  <= 1'b0;
    end else if (!play_en) begin
      state      <= PS_IDLE;
      slot       <= '0;
      word_idx   <= '0;
      fetch_addr <= '0;
      pat_out    <= '0;
      pat_valid  <= 1'b0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          fetch_addr <= addr_next;
          state      <= PS_PRIME;
        end
        PS_PRIME: begin
          cur_word   <= fetch_data;
          word_idx   <= '0;
          slot       <= '0;
          fetch_addr <= addr_next;
          state      <= PS_RUN;
        end
        PS_RUN: begin
          pat_out   <= lane_sel;
          pat_valid <= 1'b1;
          if (slot == LAST_SLOT) begin
            slot       <= '0;
            cur_word   <= fetch_data;
            fetch_addr <= addr_next;
            word_idx   <= (word_idx == LAST_WORD) ? '0 : word_idx + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_valid |-> (pat_out == '0));

  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> (!pat_valid && idle));

  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && play_en) |=> pat_valid);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && play_en && slot == LAST_SLOT && word_idx == LAST_WORD)
      |=> (word_idx == '0 && state == PS_RUN));

endmodule

// File: rtl/pp_swap.sv
module pp_swap (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic idle,
  input  logic wrap_fetch,
  output logic active_bank,
  output logic read_bank,
  output logic swap_done
);

  logic pending;
  logic commit;

  // A pending request is honoured while idle, or at the read of the
  // next frame's first word, so that read already uses the new bank.
  assign commit    = pending && (idle || wrap_fetch);
  assign read_bank = commit ? ~active_bank : active_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      active_bank <= 1'b0;
      swap_done   <= 1'b0;
    end else begin
      pending   <= commit ? 1'b0 : (pending | swap_req);
      swap_done <= commit;
      if (commit) active_bank <= ~active_bank;
    end
  end

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |=> !swap_done);

  p_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |-> (active_bank != $past(active_bank)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_done |-> $stable(active_bank));

endmodule

// File: rtl/pattern_player.sv
module pattern_player #(
  parameter int FRAME_WORDS = 625,
  parameter int LANE_W      = 8,
  parameter int SLOTS       = 4,
  localparam int WORD_W     = LANE_W * SLOTS,
  localparam int ADDR_W     = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_en,
  input  logic              swap_req,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic [LANE_W-1:0] pat_out,
  output logic              pat_valid,
  output logic              swap_done
);

  localparam int BANKS = 2;

  logic              fetch_en;
  logic [ADDR_W-1:0] fetch_addr;
  logic              wrap_fetch;
  logic              idle;
  logic              active_bank;
  logic              read_bank;
  logic              host_bank;
  logic              play_sel_q;
  logic              host_sel_q;
  logic [WORD_W-1:0] fetch_data;
  logic [WORD_W-1:0] pa_data [BANKS];
  logic [WORD_W-1:0] pb_data [BANKS];

  assign host_bank = ~active_bank;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic mine_host;
    logic mine_play;
    assign mine_host = (host_bank == b[0]);
    assign mine_play = (read_bank == b[0]);

    pp_bank #(
      .DEPTH (FRAME_WORDS),
      .WIDTH (WORD_W),
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk    (clk),
      .wr_en  (host_we && mine_host),
      .wr_addr(host_addr),
      .wr_data(host_wdata),
      .pa_en  (fetch_en && mine_play),
      .pa_addr(fetch_addr),
      .pa_data(pa_data[b]),
      .pb_en  (host_re && mine_host),
      .pb_addr(host_addr),
      .pb_data(pb_data[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_sel_q <= 1'b0;
      host_sel_q <= 1'b1;
    end else begin
      if (fetch_en) play_sel_q <= read_bank;
      if (host_re)  host_sel_q <= host_bank;
    end
  end

  assign fetch_data = pa_data[play_sel_q];
  assign host_rdata = pb_data[host_sel_q];

  pp_swap u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_req   (swap_req),
    .idle       (idle),
    .wrap_fetch (wrap_fetch),
    .active_bank(active_bank),
    .read_bank  (read_bank),
    .swap_done  (swap_done)
  );

  pp_seq #(
    .FRAME_WORDS(FRAME_WORDS),
    .LANE_W     (LANE_W),
    .SLOTS      (SLOTS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .play_en   (play_en),
    .fetch_data(fetch_data),
    .fetch_en  (fetch_en),
    .fetch_addr(fetch_addr),
    .wrap_fetch(wrap_fetch),
    .idle      (idle),
    .pat_out   (pat_out),
    .pat_valid (pat_valid)
  );

  // Playback always reads the bank the host cannot reach after this edge.
  p_host_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !swap_done) |=> (play_sel_q != host_bank));

endmodule

// File: tb/tb_pattern_player.sv
module tb_pattern_player;

  localparam int FW  = 4;
  localparam int PPF = 4 * FW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        play_en = 1'b0;
  logic        swap_req = 1'b0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  pat_out;
  logic        pat_valid;
  logic        swap_done;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  pattern_player #(.FRAME_WORDS(FW)) dut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .swap_req(swap_req),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pat_out(pat_out), .pat_valid(pat_valid), .swap_done(swap_done)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int v, int w, int b);
    return 8'(v * 32 + w * 4 + b + 1);
  endfunction

  function automatic logic [31:0] word(int v, int w);
    return {pat(v, w, 3), pat(v, w, 2), pat(v, w, 1), pat(v, w, 0)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  // Plays n patterns, starting at position pos of version ver.
  int ver, nver, pos, fr;
  bit armed;

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    check(pat_out == 0 && !pat_valid && !swap_done, "R1", {pat_valid, swap_done, pat_out}, 0);

    // R5: fill inactive bank (bank 1) with version 1 while idle
    for (int w = 0; w < FW; w++) begin
      host_we = 1'b1; host_addr = 2'(w); host_wdata = word(1, w);
      step();
    end
    host_we = 1'b0;
    // R6: read back
    for (int w = 0; w < FW; w++) begin
      host_re = 1'b1; host_addr = 2'(w);
      step();
      host_re = 1'b0;
      check(host_rdata == word(1, w), "R6", host_rdata, word(1, w));
    end
    step();
    check(host_rdata == word(1, FW - 1), "R6 hold", host_rdata, word(1, FW - 1));

    // R9: idle swap, done on second edge after request
    swap_req = 1'b1;
    step();
    swap_req = 1'b0;
    check(!swap_done, "R9 early", swap_done, 0);
    step();
    check(swap_done, "R9", swap_done, 1);
    step();
    check(!swap_done, "R9 pulse", swap_done, 0);

    // R2: start playback
    play_en = 1'b1;
    step();
    check(!pat_valid, "R2 lat1", pat_valid, 0);
    step();
    check(!pat_valid, "R2 lat2", pat_valid, 0);

    ver = 1; nver = 1; pos = 0; fr = 0; armed = 0;
    for (int i = 0; i < 6 * PPF; i++) begin
      step();
      // R3/R4/R7: every pattern, across word edges, wrap and swap
      check(pat_valid && pat_out == pat(ver, pos / 4, pos % 4),
            (fr > 0 && pos == 0) ? "R4/R7" : "R3",
            {23'd0, pat_valid, pat_out}, {24'd1, pat(ver, pos / 4, pos % 4)});
      // R8/R11: done pulse exactly once, at in-frame pattern PPF-5
      check(swap_done == (armed && pos == PPF - 5), "R8/R11", swap_done,
            (armed && pos == PPF - 5));
      // R6 read check for the previous cycle's request
      if (i > FW && i <= 2 * FW)
        check(host_rdata == word(2, i - 1 - FW), "R6 play", host_rdata, word(2, i - 1 - FW));
      // stimulus for next edge
      host_we = (i < FW);
      host_addr = (i < FW) ? 2'(i) : 2'(i - FW);
      host_wdata = word(2, i);
      host_re = (i >= FW && i < 2 * FW);
      // R7/R11: two requests in frame 2
      swap_req = (fr == 2 && (pos == 1 || pos == 2));
      if (fr == 2 && pos == 1) begin armed = 1; nver = 2; end
      if (pos == PPF - 1) begin
        pos = 0; fr++;
        if (armed) begin ver = nver; armed = 0; end
      end else pos++;
    end
    host_we = 1'b0; host_re = 1'b0; swap_req = 1'b0;

    // R10: disable
    play_en = 1'b0;
    step();
    check(!pat_valid && pat_out == 0, "R10 off", {pat_valid, pat_out}, 0);

    // R5/R8: bank 1 is now host side, still version 1
    for (int w = 0; w < FW; w++) begin
      host_re = 1'b1; host_addr = 2'(w);
      step();
      host_re = 1'b0;
      check(host_rdata == word(1, w), "R5/R8 readback", host_rdata, word(1, w));
    end

    // R9: idle swap back to bank 1
    swap_req = 1'b1;
    step();
    swap_req = 1'b0;
    step();
    check(swap_done, "R9 again", swap_done, 1);
    step();

    // R10: restart at word 0 of bank 1
    play_en = 1'b1;
    step(); step();
    for (int p = 0; p < PPF + 4; p++) begin
      step();
      check(pat_valid && pat_out == pat(1, (p % PPF) / 4, p % 4), "R10 restart",
            {23'd0, pat_valid, pat_out}, {24'd1, pat(1, (p % PPF) / 4, p % 4)});
    end
    play_en = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule